// File: doc/BRIEF.md
# Buffered Serial Peripheral Interface Master

This block is a serial peripheral interface master that sits behind a small register-style host port. The host pushes bytes into a transmit queue. A shift engine serialises each byte MSB first on the data-out line, using any of the four clock polarity and phase combinations. At the same edges it collects one byte from the data-in line into a receive queue. The serial clock is derived from the block clock through a power-of-two divider.

Up to three active-low slave-select lines are produced from a four-bit select field. In normal decoding the lowest zero bit of the field picks the slave, so at most one line is low. In external-decode mode the low three field bits go out unchanged, so an off-chip decoder can use them. Two control bits choose, independently, whether the hardware frames the select line around a burst and whether a burst starts automatically or waits for a host start command. Queue status flags compare the fill levels against host-programmable thresholds.

Register map (host_addr): 0 control, 1 enable (bit 0), 2 transmit data (write), 3 receive data (read pops), 4 status, 5 receive threshold, 6 transmit threshold. Control bits: [0] clock polarity, [1] clock phase, [4:2] divider field, [8:5] select field, [9] external decode, [10] manual start, [11] manual select, [12] start command (write-only pulse). Status bits: [0] receive level reached, [1] transmit below level, [2] transmit full, [3] busy.

Top module: `spim_top`

## Requirements
- R1: After reset all select lines are high, the serial clock is low, the thresholds are 1 and the status word reads 0x0002.
- R2: Between transfers the serial clock rests at the polarity bit (control[0]). Data out is MSB first and valid at the sampling edge: the leading edge when the phase bit (control[1]) is 0, the trailing edge when it is 1.
- R3: Every transmitted byte produces exactly one received byte, assembled MSB first from data in at the same sampling edges, and popped in order from address 3.
- R4: With divider field n (control[4:2]), each serial clock half period lasts 2^m block clocks, where m = max(n, 1).
- R5: In hardware-select mode (control[11]=0) the chosen line falls one full serial clock period before the first clock edge and rises one full period after the last edge of the final queued byte. It stays high while idle.
- R6: In normal decoding the select field maps 1111 to no slave; otherwise slave 0 when bit 0 is 0, slave 1 when bits 1:0 are 01, slave 2 when bits 2:0 are 011, and none for 0111. At most one line is low.
- R7: With external decode (control[9]=1) the select lines carry bits 2:0 of the field directly whenever they are driven.
- R8: In manual-start mode (control[10]=1) queued bytes wait until the host writes control with bit 12 set; that bit is a one-cycle pulse and then reads back 0.
- R9: With the enable register at 0 no clock edge is produced, and dropping the enable returns the engine to idle on the next cycle.
- R10: A write to a full transmit queue is discarded, and a read of an empty receive queue returns 0 without effect.
- R11: Status bit 0 is 1 exactly when the receive queue holds at least the receive threshold (address 5) bytes.
- R12: Status bit 1 is 1 exactly when the transmit queue holds fewer bytes than the transmit threshold (address 6), and status bit 2 is 1 exactly when it is full.
- R13: In manual-select mode (control[11]=1) the decoded select lines follow the field whenever the block is enabled, with or without a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_wdata | input | 16 | Write data |
| host_rd | input | 1 | Read strobe (pops the receive queue at address 3) |
| host_rdata | output | 16 | Combinational read data for host_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 3 | Active-low slave selects |

## Verification
On every cycle, the embedded properties check three things: the one-cold shape of the select lines in normal decoding, that dropping the enable returns the engine to idle, and that the clock sits at its rest level while the select lead-in runs. They also bound the queue fill counters. The framing gaps, the half-period length per divider setting, and the bit order at the sampling edge for each mode can only be shown by the bench's transfer scenarios. The same holds for the threshold comparisons across fill levels, the gating by manual start, and the discarded overflow byte.

// File: rtl/spim_pkg.sv
package spim_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} eng_st_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_EN   = 3'd1;
    localparam logic [2:0] A_TX   = 3'd2;
    localparam logic [2:0] A_RX   = 3'd3;
    localparam logic [2:0] A_ST   = 3'd4;
    localparam logic [2:0] A_RXTH = 3'd5;
    localparam logic [2:0] A_TXTH = 3'd6;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int DEPTH = 128,
    parameter int DW    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push,
    input  logic [DW-1:0]               wdata,
    input  logic                        pop,
    output logic [DW-1:0]               rdata,
    output logic [$clog2(DEPTH):0]      count,
    output logic                        full,
    output logic                        empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_s;

    fifo_s q, d;
    logic [DW-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[q.rp];
    assign count   = q.cnt;

    always_comb begin
        d = q;
        if (do_push) d.wp = q.wp + 1'b1;
        if (do_pop)  d.rp = q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= wdata;
    end

    // R10
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/spim_sel.sv
module spim_sel #(
    parameter int NS = 3
) (
    input  logic [NS:0]   field,
    input  logic          ext,
    input  logic          drive,
    output logic [NS-1:0] ss_n
);
    logic [NS-1:0] pick;

    for (genvar i = 0; i < NS; i++) begin : g_dec
        if (i == 0) begin : g_first
            assign pick[i] = !field[0];
        end else begin : g_rest
            assign pick[i] = !field[i] && (&field[i-1:0]);
        end
    end

    always_comb begin
        ss_n = '1;
        if (drive) ss_n = ext ? field[NS-1:0] : ~pick;
    end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int DW = 8,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cpol,
    input  logic          cpha,
    input  logic [BW-1:0] baud,
    input  logic          man_start,
    input  logic          go,
    input  logic          tx_valid,
    input  logic [DW-1:0] tx_data,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [DW-1:0] rx_data,
    input  logic          miso,
    output logic          sclk,
    output logic          mosi,
    output logic          busy
);
    localparam int HCW = 1 << BW;
    localparam int EW  = $clog2(2 * DW);
    localparam logic [EW-1:0] ELAST = EW'(2 * DW - 1);

    typedef struct packed {
        eng_st_e        st;
        logic [HCW-1:0] hcnt;
        logic [EW-1:0]  ecnt;
        logic [DW-1:0]  sh;
        logic [DW-1:0]  rx;
        logic           mosi;
        logic           sclk;
        logic           pend;
    } eng_s;

    eng_s q, d;
    logic [BW-1:0]  n_eff;
    logic [HCW-1:0] half_m1;
    logic           tick, load;
    eng_st_e        st_q;

    assign n_eff   = (baud == '0) ? BW'(1) : baud;
    assign half_m1 = (HCW'(1) << n_eff) - HCW'(1);
    assign tick    = (q.hcnt == half_m1);

    always_comb begin
        d       = q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        load    = 1'b0;
        if (!en) begin
            d.st   = ST_IDLE;
            d.sclk = cpol;
            d.hcnt = '0;
            d.ecnt = '0;
            d.pend = 1'b0;
        end else begin
            d.hcnt = tick ? '0 : q.hcnt + 1'b1;
            case (q.st)
                ST_IDLE: begin
                    d.sclk = cpol;
                    d.hcnt = '0;
                    d.ecnt = '0;
                    if (go) d.pend = 1'b1;
                    if (tx_valid && (!man_start || go || q.pend)) begin
                        d.st   = ST_LEAD;
                        d.pend = 1'b0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        load = 1'b1;
                        d.st = ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        d.sclk = ~q.sclk;
                        d.ecnt = q.ecnt + 1'b1;
                        if (!q.ecnt[0]) begin
                            if (cpha) begin
                                d.mosi = q.sh[DW-1];
                                d.sh   = q.sh << 1;
                            end else begin
                                d.rx = {q.rx[DW-2:0], miso};
                            end
                        end else begin
                            if (cpha) begin
                                d.rx = {q.rx[DW-2:0], miso};
                            end else if (q.ecnt != ELAST) begin
                                d.mosi = q.sh[DW-2];
                                d.sh   = q.sh << 1;
                            end
                        end
                        if (q.ecnt == ELAST) begin
                            rx_push = 1'b1;
                            d.ecnt  = '0;
                            if (tx_valid) load = 1'b1;
                            else          d.st = ST_TRAIL;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        d.ecnt = q.ecnt + 1'b1;
                        if (q.ecnt != '0) begin
                            d.st   = ST_IDLE;
                            d.ecnt = '0;
                        end
                    end
                end
            endcase
            if (load) begin
                tx_pop = 1'b1;
                d.sh   = tx_data;
                if (!cpha) d.mosi = tx_data[DW-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign rx_data = d.rx;
    assign sclk    = q.sclk;
    assign mosi    = q.mosi;
    assign st_q    = q.st;
    assign busy    = (q.st != ST_IDLE);

    // R9
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q == ST_IDLE));

    // R2
    lead_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LEAD) |-> (sclk == cpol));
endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int NS    = 3,
    parameter int HDW   = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2:0]     host_addr,
    input  logic           host_wr,
    input  logic [HDW-1:0] host_wdata,
    input  logic           host_rd,
    output logic [HDW-1:0] host_rdata,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic [NS-1:0]  ss_n
);
    localparam int DW     = 8;
    localparam int BW     = 3;
    localparam int FW     = NS + 1;
    localparam int CW     = $clog2(DEPTH) + 1;
    localparam int CS_LSB = 2 + BW;
    localparam int EXT_B  = CS_LSB + FW;
    localparam int MST_B  = EXT_B + 1;
    localparam int MSEL_B = EXT_B + 2;
    localparam int GO_B   = EXT_B + 3;

    typedef struct packed {
        logic          cpol;
        logic          cpha;
        logic [BW-1:0] baud;
        logic [FW-1:0] field;
        logic          ext;
        logic          mstart;
        logic          msel;
        logic          en;
        logic          go;
        logic [CW-1:0] rxth;
        logic [CW-1:0] txth;
    } cfg_s;

    cfg_s q, d;

    logic          tx_push, tx_pop, tx_full, tx_empty;
    logic [DW-1:0] tx_head;
    logic [CW-1:0] tx_cnt;
    logic          rx_push, rx_pop, rx_full, rx_empty;
    logic [DW-1:0] rx_head, rx_byte;
    logic [CW-1:0] rx_cnt;
    logic          busy;
    logic [3:0]    status;

    assign tx_push = host_wr && (host_addr == A_TX);
    assign rx_pop  = host_rd && (host_addr == A_RX);

    always_comb begin
        d    = q;
        d.go = 1'b0;
        if (host_wr) begin
            case (host_addr)
                A_CTRL: begin
                    d.cpol   = host_wdata[0];
                    d.cpha   = host_wdata[1];
                    d.baud   = host_wdata[2 +: BW];
                    d.field  = host_wdata[CS_LSB +: FW];
                    d.ext    = host_wdata[EXT_B];
                    d.mstart = host_wdata[MST_B];
                    d.msel   = host_wdata[MSEL_B];
                    d.go     = host_wdata[GO_B];
                end
                A_EN:    d.en   = host_wdata[0];
                A_RXTH:  d.rxth = host_wdata[CW-1:0];
                A_TXTH:  d.txth = host_wdata[CW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{field: '1, rxth: CW'(1), txth: CW'(1), default: '0};
        else        q <= d;
    end

    spim_fifo #(.DEPTH(DEPTH), .DW(DW)) i_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(host_wdata[DW-1:0]),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spim_fifo #(.DEPTH(DEPTH), .DW(DW)) i_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spim_engine #(.DW(DW), .BW(BW)) i_eng (
        .clk(clk), .rst_n(rst_n), .en(q.en), .cpol(q.cpol), .cpha(q.cpha),
        .baud(q.baud), .man_start(q.mstart), .go(q.go),
        .tx_valid(!tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_byte), .miso(miso),
        .sclk(sclk), .mosi(mosi), .busy(busy)
    );

    spim_sel #(.NS(NS)) i_sel (
        .field(q.field), .ext(q.ext),
        .drive(q.en && (q.msel || busy)), .ss_n(ss_n)
    );

    assign status = {busy, tx_full, (tx_cnt < q.txth), (rx_cnt >= q.rxth)};

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_CTRL: begin
                host_rdata[0]              = q.cpol;
                host_rdata[1]              = q.cpha;
                host_rdata[2 +: BW]        = q.baud;
                host_rdata[CS_LSB +: FW]   = q.field;
                host_rdata[EXT_B]          = q.ext;
                host_rdata[MST_B]          = q.mstart;
                host_rdata[MSEL_B]         = q.msel;
            end
            A_EN:   host_rdata[0] = q.en;
            A_RX:   if (!rx_empty) host_rdata[DW-1:0] = rx_head;
            A_ST:   host_rdata[3:0] = status;
            A_RXTH: host_rdata[CW-1:0] = q.rxth;
            A_TXTH: host_rdata[CW-1:0] = q.txth;
            default: ;
        endcase
    end

    // R6
    one_cold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ext |-> ($countones(~ss_n) <= 1));
endmodule

// File: tb/test_spim_top.sv
module test_spim_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        sclk, mosi, miso;
    logic [2:0]  ss_n;

    always #10 clk = ~clk;
    assign miso = ~mosi;

    spim_top #(.DEPTH(8), .NS(3), .HDW(16)) i_spim_top (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
    );

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(negedge clk);
        host_addr = a; host_wdata = v; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input bit pop, output logic [15:0] v);
        @(negedge clk);
        host_addr = a; host_rd = pop;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        repeat (4) @(negedge clk);
        v = 16'h8;
        for (int g = 0; g < 5000 && v[3]; g++) rd(3'd4, 1'b0, v);
    endtask

    // monitor of the serial lines
    bit          mon_cpol = 0, mon_cpha = 0;
    logic        last_sclk = 1'b0;
    logic [2:0]  last_ss = 3'b111, ss_seen = 3'b111;
    logic        pol_at_fall = 1'b0;
    int          cyc = 0, tog_cnt = 0, last_tog = 0, fall_cyc = 0;
    int          lead_gap = 0, trail_gap = 0, imin = 1000, imax = 0, nbit = 0, ncap = 0;
    bit          first = 1'b0;
    logic [7:0]  capsh = '0;
    logic [7:0]  cap [16];

    always @(negedge clk) begin
        cyc++;
        if (ss_n != 3'b111 && last_ss == 3'b111) begin
            fall_cyc = cyc; first = 1'b1; ss_seen = ss_n; pol_at_fall = sclk;
        end
        if (ss_n == 3'b111 && last_ss != 3'b111) trail_gap = cyc - last_tog;
        if (sclk !== last_sclk) begin
            tog_cnt++;
            if (ss_n != 3'b111) begin
                if (first) begin
                    lead_gap = cyc - fall_cyc; first = 1'b0;
                end else begin
                    if (cyc - last_tog < imin) imin = cyc - last_tog;
                    if (cyc - last_tog > imax) imax = cyc - last_tog;
                end
                if ((sclk != mon_cpol) == !mon_cpha) begin
                    capsh = {capsh[6:0], mosi};
                    nbit++;
                    if (nbit == 8) begin
                        cap[ncap % 16] = capsh; ncap++; nbit = 0;
                    end
                end
            end
            last_tog = cyc;
        end
        last_sclk = sclk;
        last_ss = ss_n;
    end

    function automatic logic [2:0] exp_ss(input int f, input bit ext);
        logic [3:0] fv;
        fv = 4'(f);
        if (ext)        return fv[2:0];
        if (!fv[0])     return 3'b110;
        if (!fv[1])     return 3'b101;
        if (!fv[2])     return 3'b011;
        return 3'b111;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [7:0]  txb [3];
        int          half, t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(ss_n == 3'b111, "R1 ss_n", int'(ss_n), 7);
        chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
        rd(3'd4, 1'b0, v);
        chk(v == 16'h0002, "R1 status", int'(v), 2);

        // R2 R3 R4 R5: all modes, several dividers
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 3; b++) begin
                half = 1 << ((b == 0) ? 1 : b);
                mon_cpol = m[0]; mon_cpha = m[1];
                wr(3'd0, 16'(m[0] | (m[1] << 1) | (b << 2)));
                wr(3'd1, 16'd1);
                imin = 1000; imax = 0; ncap = 0; nbit = 0;
                for (int i = 0; i < 3; i++) begin
                    txb[i] = 8'(8'hA5 ^ (m * 37 + b * 11 + i * 73));
                    wr(3'd2, {8'h0, txb[i]});
                end
                wait_idle();
                chk(ncap == 3, "R2 byte count", ncap, 3);
                for (int i = 0; i < 3; i++) begin
                    chk(cap[i] == txb[i], "R2 mosi byte", int'(cap[i]), int'(txb[i]));
                    rd(3'd3, 1'b1, v);
                    chk(v == {8'h0, ~txb[i]}, "R3 rx byte", int'(v), int'(~txb[i]));
                end
                rd(3'd3, 1'b1, v);
                chk(v == 16'h0, "R3 no extra byte", int'(v), 0);
                chk(imin == half && imax == half, "R4 half period", imin * 1000 + imax, half * 1001);
                chk(lead_gap == 2 * half, "R5 lead gap", lead_gap, 2 * half);
                chk(trail_gap == 2 * half, "R5 trail gap", trail_gap, 2 * half);
                chk(ss_seen == 3'b110, "R5 select line", int'(ss_seen), 6);
                chk(pol_at_fall == m[0] && sclk == m[0], "R2 rest level", int'(sclk), m[0]);
                chk(ss_n == 3'b111, "R5 idle release", int'(ss_n), 7);
                wr(3'd1, 16'd0);
            end
        end
        mon_cpol = 0; mon_cpha = 0;

        // R6 R7 R13: decode sweep in manual-select mode
        wr(3'd1, 16'd1);
        for (int e = 0; e < 2; e++) begin
            for (int f = 0; f < 16; f++) begin
                wr(3'd0, 16'((1 << 11) | (e << 9) | (f << 5) | (1 << 2)));
                chk(ss_n == exp_ss(f, e[0]), e ? "R7 external pattern" : "R6 R13 decode",
                    int'(ss_n), int'(exp_ss(f, e[0])));
            end
        end
        wr(3'd0, 16'((0 << 5) | (1 << 2)));
        chk(ss_n == 3'b111, "R5 idle hw select", int'(ss_n), 7);

        // R8 manual start
        wr(3'd0, 16'((1 << 10) | (1 << 2)));
        t0 = tog_cnt;
        wr(3'd2, 16'h003C);
        wr(3'd2, 16'h00C3);
        repeat (40) @(negedge clk);
        chk(tog_cnt == t0, "R8 held without start", tog_cnt - t0, 0);
        rd(3'd0, 1'b0, v);
        chk(v[12] == 1'b0, "R8 start reads 0", int'(v[12]), 0);
        wr(3'd0, 16'((1 << 12) | (1 << 10) | (1 << 2)));
        wait_idle();
        chk(tog_cnt - t0 == 32, "R8 edges after start", tog_cnt - t0, 32);
        rd(3'd3, 1'b1, v);
        chk(v == 16'h00C3, "R8 first byte", int'(v), 16'hC3);
        rd(3'd3, 1'b1, v);
        chk(v == 16'h003C, "R8 second byte", int'(v), 16'h3C);

        // R9 R10 R12: fill while disabled, sweep transmit thresholds
        wr(3'd1, 16'd0);
        wr(3'd0, 16'(1 << 2));
        t0 = tog_cnt;
        for (int k = 0; k <= 8; k++) begin
            if (k > 0) wr(3'd2, 16'(8'h10 + k));
            for (int th = 1; th <= 8; th++) begin
                wr(3'd6, 16'(th));
                rd(3'd4, 1'b0, v);
                chk(v[1] == (k < th), "R12 tx level flag", int'(v[1]), int'(k < th));
                chk(v[2] == (k == 8), "R12 tx full flag", int'(v[2]), int'(k == 8));
            end
        end
        wr(3'd6, 16'd1);
        wr(3'd2, 16'h00EE);
        chk(tog_cnt == t0, "R9 disabled no edges", tog_cnt - t0, 0);
        wr(3'd1, 16'd1);
        wait_idle();
        chk(tog_cnt - t0 == 128, "R10 overflow byte dropped", tog_cnt - t0, 128);

        // R11 R10: drain with receive threshold sweep
        for (int c = 8; c >= 1; c--) begin
            for (int th = 1; th <= 8; th++) begin
                wr(3'd5, 16'(th));
                rd(3'd4, 1'b0, v);
                chk(v[0] == (c >= th), "R11 rx level flag", int'(v[0]), int'(c >= th));
            end
            rd(3'd3, 1'b1, v);
            chk(v == {8'h0, ~(8'(8'h10 + 9 - c))}, "R3 drained byte",
                int'(v), int'(~(8'(8'h10 + 9 - c))));
        end
        wr(3'd5, 16'd1);
        rd(3'd3, 1'b1, v);
        chk(v == 16'h0, "R10 empty read", int'(v), 0);
        rd(3'd4, 1'b0, v);
        chk(v[0] == 1'b0, "R10 still empty", int'(v[0]), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule